// File: doc/BRIEF.md
# UART FIFO Front End with Loopback

This block is the register-facing half of a serial port. A 32-bit bus reaches it through a small word-addressed window. Behind that window sit a transmit queue and a receive queue, each holding 32 bytes. On the other side, the bit-timing engine takes bytes from the transmit queue over a valid/ready stream. It hands received bytes back with a one-cycle valid strobe. The block holds the line settings: the baud increment, parity enable and sense, and filter enable. It drives them straight to the engine as configuration outputs.

Software loads bytes through the write-data word and drains received bytes through the read-data word. A read of the read-data word removes the byte it returns. Two loopback paths support self-test. In system loopback, written bytes skip the line and land in the receive queue. In line loopback, every byte arriving from the engine is also queued for transmission. Transmission can be held off by clearing the transmit enable: bytes keep accumulating and go out once it is set again. Any byte refused by a full receive queue produces a single-cycle overflow pulse for the interrupt logic.

Top module: `uart_fifo_frontend`

## Requirements
- R1: After reset the control word (0x0C) and both queue levels (0x20) read zero, and the live status word (0x10) reads 0x3C.
- R2: The control word at 0x0C keeps bits 0 (transmit enable), 1 (receive enable), 2 (filter enable), 4 (system loopback), 5 (line loopback), 6 (parity enable), 7 (odd parity) and 31:16 (baud increment); bit 3 and bits 15:8 read zero. Bits 2, 6, 7 and 31:16 appear on the matching configuration outputs.
- R3: A byte written to 0x18 (bits 7:0) while transmit enable is clear is queued and tx_valid stays low. Once enabled, the queued bytes are presented on tx_data in write order, and each one is removed on a cycle with tx_valid and tx_ready both high.
- R4: The transmit queue holds 32 bytes. A write while it is full is ignored, and its level reads 32 in bits 5:0 of 0x20.
- R5: With receive enable set, a strobed byte enters the receive queue, and its level shows in bits 21:16 of 0x20. A read of 0x14 returns the oldest byte in bits 7:0 and removes it.
- R6: With receive enable clear, strobed bytes are discarded.
- R7: A byte offered to a full receive queue is dropped, and ovf_event is high for exactly the one cycle after the refused byte.
- R8: Reading 0x14 while the receive queue is empty returns zero and leaves the level at zero.
- R9: With system loopback set, a write to 0x18 enters the receive queue, whatever the receive enable, and the transmit level is unchanged; bytes strobed in from the engine are ignored.
- R10: With line loopback set, each strobed byte is also queued for transmission and offered on tx_data even while transmit enable is clear. It still enters the receive queue when receive is enabled.
- R11: Writing 0x1C with bit 0 set empties the receive queue, and with bit 1 set empties the transmit queue. The same write stores the receive threshold code (bits 4:2) and the transmit threshold code (bits 6:5), which read back there; bits 1:0 read zero.
- R12: The live status word gives transmit full (bit 0), receive full (bit 1), transmit empty (bit 2), transmit idle (bit 3, equal to transmit empty), receive idle (bit 4, always one) and receive empty (bit 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of the accessed word; bits 1:0 must be zero |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a read of 0x14 removes a byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_re |
| tx_data | output | 8 | Byte at the head of the transmit queue |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Engine takes the transmit byte |
| rx_data | input | 8 | Received byte from the engine |
| rx_valid | input | 1 | One-cycle strobe for rx_data |
| ovf_event | output | 1 | One-cycle pulse after a byte was refused by a full receive queue |
| cfg_baud_inc | output | 16 | Baud increment for the engine |
| cfg_parity_en | output | 1 | Parity enable for the engine |
| cfg_parity_odd | output | 1 | Odd parity select |
| cfg_filt_en | output | 1 | Line filter enable |

## Verification
The bench fills each queue to exactly 32 entries and offers one more. A queue that wraps its write pointer would then overwrite the oldest byte, and the drain order would come back wrong; the overflow pulse would be missing or stuck. It reads the receive word from an empty queue. A design that moves its read pointer there would later return stale bytes, and the level would underflow. It also runs both loopback modes with the opposite gate cleared. A design that gates the echo with transmit enable, or routes system-loopback bytes through the transmit queue, shows a wrong level or a silent tx_valid.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    localparam int unsigned FIFO_DEPTH = 32;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned ADDR_W     = 6;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned WORD_W     = ADDR_W - 2;

    localparam logic [WORD_W-1:0] IDX_CTRL  = WORD_W'(3);
    localparam logic [WORD_W-1:0] IDX_STAT  = WORD_W'(4);
    localparam logic [WORD_W-1:0] IDX_RDAT  = WORD_W'(5);
    localparam logic [WORD_W-1:0] IDX_WDAT  = WORD_W'(6);
    localparam logic [WORD_W-1:0] IDX_FCTL  = WORD_W'(7);
    localparam logic [WORD_W-1:0] IDX_FSTAT = WORD_W'(8);

    typedef struct packed {
        logic [15:0] baud_inc;
        logic        parity_odd;
        logic        parity_en;
        logic        line_lb;
        logic        sys_lb;
        logic        filt_en;
        logic        rx_en;
        logic        tx_en;
    } fe_ctrl_t;

    typedef struct packed {
        logic [2:0] rx_wm;
        logic [1:0] tx_wm;
    } fe_wm_t;

endpackage

// File: rtl/uart_fe_byte_fifo.sv
module uart_fe_byte_fifo #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned LVL_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W-1:0] wr_ptr;
        logic [LVL_W-1:0] count;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.count == LVL_W'(DEPTH));
    assign empty   = (st_q.count == '0);
    assign level   = st_q.count;
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rdata   = empty ? '0 : mem_q[st_q.rd_ptr];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr_ptr = ptr_next(st_q.wr_ptr);
            if (do_pop)  st_d.rd_ptr = ptr_next(st_q.rd_ptr);
            case ({do_push, do_pop})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr_ptr] <= wdata;
    end

    // R4
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R4
    full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> $stable(level));

    // R8
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> (level == '0));

endmodule

// File: rtl/uart_fe_cfg_regs.sv
module uart_fe_cfg_regs
    import uart_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              fctl_we,
    input  logic [DATA_W-1:0] wdata,
    output fe_ctrl_t          ctrl,
    output fe_wm_t            wm
);

    typedef struct packed {
        fe_ctrl_t ctrl;
        fe_wm_t   wm;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (ctrl_we) begin
            cfg_d.ctrl.tx_en      = wdata[0];
            cfg_d.ctrl.rx_en      = wdata[1];
            cfg_d.ctrl.filt_en    = wdata[2];
            cfg_d.ctrl.sys_lb     = wdata[4];
            cfg_d.ctrl.line_lb    = wdata[5];
            cfg_d.ctrl.parity_en  = wdata[6];
            cfg_d.ctrl.parity_odd = wdata[7];
            cfg_d.ctrl.baud_inc   = wdata[31:16];
        end
        if (fctl_we) begin
            cfg_d.wm.rx_wm = wdata[4:2];
            cfg_d.wm.tx_wm = wdata[6:5];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ctrl = cfg_q.ctrl;
    assign wm   = cfg_q.wm;

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(ctrl));

endmodule

// File: rtl/uart_fifo_frontend.sv
module uart_fifo_frontend
    import uart_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              ovf_event,
    output logic [15:0]       cfg_baud_inc,
    output logic              cfg_parity_en,
    output logic              cfg_parity_odd,
    output logic              cfg_filt_en
);

    localparam int unsigned LVL_W = $clog2(FIFO_DEPTH) + 1;

    typedef struct packed {
        logic ovf;
    } top_state_t;

    fe_ctrl_t ctrl;
    fe_wm_t   wm;
    top_state_t top_d, top_q;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              ctrl_we, fctl_we, wdat_wr, rdat_rd;
    logic              rx_clr, tx_clr, echo;
    logic              tx_push, tx_pop, rx_push, rx_from_bus, rx_from_line;
    logic [BYTE_W-1:0] tx_push_data, rx_push_data, rx_head;
    logic [LVL_W-1:0]  tx_level, rx_level;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rd_word;

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign ctrl_we = bus_we && aligned && (word == IDX_CTRL);
    assign fctl_we = bus_we && aligned && (word == IDX_FCTL);
    assign wdat_wr = bus_we && aligned && (word == IDX_WDAT);
    assign rdat_rd = bus_re && aligned && (word == IDX_RDAT);
    assign rx_clr  = fctl_we && bus_wdata[0];
    assign tx_clr  = fctl_we && bus_wdata[1];

    uart_fe_cfg_regs cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .fctl_we (fctl_we),
        .wdata   (bus_wdata),
        .ctrl    (ctrl),
        .wm      (wm)
    );

    // Transmit side: the echoed line byte takes the queue slot over a bus write.
    assign echo         = rx_valid && ctrl.line_lb;
    assign tx_push      = echo || (wdat_wr && !ctrl.sys_lb);
    assign tx_push_data = echo ? rx_data : bus_wdata[BYTE_W-1:0];
    assign tx_valid     = !tx_empty && (ctrl.tx_en || ctrl.line_lb);
    assign tx_pop       = tx_valid && tx_ready;

    // Receive side: system loopback replaces the line as the only source.
    assign rx_from_bus  = wdat_wr && ctrl.sys_lb;
    assign rx_from_line = rx_valid && ctrl.rx_en && !ctrl.sys_lb;
    assign rx_push      = rx_from_bus || rx_from_line;
    assign rx_push_data = rx_from_bus ? bus_wdata[BYTE_W-1:0] : rx_data;

    uart_fe_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) tx_fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (tx_push),
        .wdata (tx_push_data),
        .pop   (tx_pop),
        .rdata (tx_data),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    uart_fe_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) rx_fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (rx_push),
        .wdata (rx_push_data),
        .pop   (rdat_rd),
        .rdata (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    always_comb begin
        top_d     = top_q;
        top_d.ovf = rx_push && rx_full && !rx_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign ovf_event = top_q.ovf;

    always_comb begin
        rd_word = '0;
        if (aligned) begin
            case (word)
                IDX_CTRL:  rd_word = {ctrl.baud_inc, 8'h00, ctrl.parity_odd, ctrl.parity_en,
                                      ctrl.line_lb, ctrl.sys_lb, 1'b0, ctrl.filt_en,
                                      ctrl.rx_en, ctrl.tx_en};
                IDX_STAT:  rd_word = {26'd0, rx_empty, 1'b1, tx_empty, tx_empty, rx_full, tx_full};
                IDX_RDAT:  rd_word[BYTE_W-1:0] = rx_head;
                IDX_FCTL:  begin
                    rd_word[4:2] = wm.rx_wm;
                    rd_word[6:5] = wm.tx_wm;
                end
                IDX_FSTAT: begin
                    rd_word[LVL_W-1:0]  = tx_level;
                    rd_word[16+:LVL_W]  = rx_level;
                end
                default:   rd_word = '0;
            endcase
        end
    end

    assign bus_rdata      = bus_re ? rd_word : '0;
    assign cfg_baud_inc   = ctrl.baud_inc;
    assign cfg_parity_en  = ctrl.parity_en;
    assign cfg_parity_odd = ctrl.parity_odd;
    assign cfg_filt_en    = ctrl.filt_en;

    // R7
    ovf_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_event |-> $past(rx_full));

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !tx_clr && !ctrl_we) |=> (tx_valid && $stable(tx_data)));

    // R9
    sys_lb_tx_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdat_wr && ctrl.sys_lb && !echo && !tx_pop && !tx_clr) |=> $stable(tx_level));

    // R6
    rx_off_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ctrl.rx_en && !wdat_wr && !rdat_rd && !rx_clr) |=> $stable(rx_level));

endmodule

// File: tb/uart_fifo_frontend_tb.sv
module uart_fifo_frontend_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        ovf_event;
    logic [15:0] cfg_baud_inc;
    logic        cfg_parity_en, cfg_parity_odd, cfg_filt_en;

    int errors = 0;
    int checks = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    uart_fifo_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .ovf_event(ovf_event),
        .cfg_baud_inc(cfg_baud_inc), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_odd(cfg_parity_odd), .cfg_filt_en(cfg_filt_en)
    );

    // Vector: op[75:74] (0 write, 1 read-compare, 2 line byte), req[73:70], addr, data, expected
    localparam int NV = 31;
    localparam logic [75:0] VEC [NV] = '{
        {2'd1, 4'd1,  6'h10, 32'h0,        32'h0000_003C}, // R1
        {2'd1, 4'd1,  6'h20, 32'h0,        32'h0},         // R1
        {2'd1, 4'd1,  6'h0C, 32'h0,        32'h0},         // R1
        {2'd0, 4'd2,  6'h0C, 32'hFFFF_FFFF, 32'h0},        // R2
        {2'd1, 4'd2,  6'h0C, 32'h0,        32'hFFFF_00F7}, // R2
        {2'd0, 4'd5,  6'h0C, 32'h2,        32'h0},         // R5
        {2'd2, 4'd5,  6'h00, 32'h5A,       32'h0},         // R5
        {2'd2, 4'd5,  6'h00, 32'hC3,       32'h0},         // R5
        {2'd1, 4'd5,  6'h20, 32'h0,        32'h0002_0000}, // R5
        {2'd1, 4'd5,  6'h14, 32'h0,        32'h5A},        // R5
        {2'd1, 4'd5,  6'h14, 32'h0,        32'hC3},        // R5
        {2'd1, 4'd8,  6'h14, 32'h0,        32'h0},         // R8
        {2'd1, 4'd8,  6'h20, 32'h0,        32'h0},         // R8
        {2'd0, 4'd6,  6'h0C, 32'h0,        32'h0},         // R6
        {2'd2, 4'd6,  6'h00, 32'h11,       32'h0},         // R6
        {2'd1, 4'd6,  6'h20, 32'h0,        32'h0},         // R6
        {2'd0, 4'd11, 6'h1C, 32'h7F,       32'h0},         // R11
        {2'd1, 4'd11, 6'h1C, 32'h0,        32'h7C},        // R11
        {2'd0, 4'd9,  6'h0C, 32'h10,       32'h0},         // R9
        {2'd0, 4'd9,  6'h18, 32'hA5,       32'h0},         // R9
        {2'd1, 4'd9,  6'h20, 32'h0,        32'h0001_0000}, // R9
        {2'd2, 4'd9,  6'h00, 32'h22,       32'h0},         // R9
        {2'd1, 4'd9,  6'h20, 32'h0,        32'h0001_0000}, // R9
        {2'd1, 4'd9,  6'h14, 32'h0,        32'hA5},        // R9
        {2'd0, 4'd3,  6'h0C, 32'h0,        32'h0},         // R3
        {2'd0, 4'd3,  6'h18, 32'h31,       32'h0},         // R3
        {2'd0, 4'd3,  6'h18, 32'h32,       32'h0},         // R3
        {2'd1, 4'd3,  6'h20, 32'h0,        32'h2},         // R3
        {2'd0, 4'd11, 6'h1C, 32'h2,        32'h0},         // R11
        {2'd1, 4'd11, 6'h20, 32'h0,        32'h0},         // R11
        {2'd1, 4'd11, 6'h1C, 32'h0,        32'h0}          // R11
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic line_byte(input logic [7:0] b);
        rx_data = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic tx_take(input string req, input logic [7:0] exp);
        check(req, {31'd0, tx_valid}, 32'd1);
        check(req, {24'd0, tx_data}, {24'd0, exp});
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][75:74])
                2'd0: bus_wr(VEC[i][69:64], VEC[i][63:32]);
                2'd1: begin
                    bus_rd(VEC[i][69:64], rd);
                    check($sformatf("R%0d vec%0d", VEC[i][73:70], i), rd, VEC[i][31:0]);
                end
                default: line_byte(VEC[i][39:32]);
            endcase
        end

        // R2: configuration outputs follow the control word
        bus_wr(6'h0C, 32'h1234_00C4);
        check("R2 baud", {16'd0, cfg_baud_inc}, 32'h1234);
        check("R2 flags", {29'd0, cfg_parity_odd, cfg_parity_en, cfg_filt_en}, 32'h7);
        bus_wr(6'h0C, 32'h0);

        // R3: held while disabled, drained in order once enabled
        bus_wr(6'h18, 32'h10);
        bus_wr(6'h18, 32'h20);
        bus_wr(6'h18, 32'h30);
        check("R3 held", {31'd0, tx_valid}, 32'd0);
        bus_wr(6'h0C, 32'h1);
        tx_take("R3 first", 8'h10);
        tx_take("R3 second", 8'h20);
        tx_take("R3 third", 8'h30);
        check("R3 drained", {31'd0, tx_valid}, 32'd0);
        bus_rd(6'h10, rd);
        check("R12 tx empty", rd, 32'h3C);

        // R4: 33rd write to the transmit queue is ignored
        bus_wr(6'h0C, 32'h0);
        for (int i = 0; i < 33; i++) bus_wr(6'h18, 32'(i));
        bus_rd(6'h20, rd);
        check("R4 level", rd, 32'h20);
        bus_rd(6'h10, rd);
        check("R12 tx full", rd, 32'h31);
        bus_wr(6'h0C, 32'h1);
        for (int i = 0; i < 32; i++) tx_take("R4 order", 8'(i));
        check("R4 extra dropped", {31'd0, tx_valid}, 32'd0);

        // R7: receive overflow
        bus_wr(6'h0C, 32'h2);
        for (int i = 0; i < 32; i++) line_byte(8'(8'h40 + i));
        check("R7 no pulse at fill", {31'd0, ovf_event}, 32'd0);
        bus_rd(6'h10, rd);
        check("R12 rx full", rd, 32'h1E);
        line_byte(8'hEE);
        check("R7 pulse", {31'd0, ovf_event}, 32'd1);
        @(negedge clk);
        check("R7 pulse ends", {31'd0, ovf_event}, 32'd0);
        bus_rd(6'h20, rd);
        check("R7 level", rd, 32'h0020_0000);
        for (int i = 0; i < 32; i++) begin
            bus_rd(6'h14, rd);
            check("R7 order", rd, 32'(8'h40 + i));
        end
        bus_rd(6'h14, rd);
        check("R8 empty read", rd, 32'h0);

        // R10: line loopback echoes with transmit disabled
        bus_wr(6'h0C, 32'h22);
        line_byte(8'h6B);
        bus_rd(6'h20, rd);
        check("R10 levels", rd, 32'h0001_0001);
        tx_take("R10 echo", 8'h6B);
        bus_rd(6'h14, rd);
        check("R10 rx copy", rd, 32'h6B);

        // R1: reset in mid run
        bus_wr(6'h0C, 32'h2);
        line_byte(8'h55);
        bus_wr(6'h18, 32'h66);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(6'h10, rd);
        check("R1 status", rd, 32'h3C);
        bus_rd(6'h20, rd);
        check("R1 levels", rd, 32'h0);
        bus_rd(6'h0C, rd);
        check("R1 ctrl", rd, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule